// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block collects completion events from a bank of DMA channels and turns them into register-visible pending flags and one level interrupt. Each channel drives three single-cycle pulses: one when half of a descriptor has moved, one when a descriptor finishes, and one when the whole descriptor chain finishes. Every channel owns a four-bit nibble in a pending word and a matching nibble in an enable word. Channels 0 to 7 share the first pair of words. Channels 8 and up share a second pair at the next word offset.

Software reads the pending words to find the cause of an interrupt. It acknowledges a cause by writing a one to that bit. Pending flags latch whether or not they are enabled. The interrupt output is high while any pending flag has its enable bit set. A separate read-only word shows one busy bit per channel, taken from the channel datapaths. The channel count is a parameter from 8 to 16.

The register port is a plain single-cycle write strobe with an address, plus a read data bus that follows the address combinationally. The port has no handshake, because every access completes in the cycle it is presented.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset, all enable and pending bits read 0 and `irq_o` is low.
- R2: A pulse on a channel's half, descriptor or chain event input sets nibble bit 0, 1 or 2 respectively. The bit is readable on the clock edge that samples the pulse, and it is set whether or not it is enabled.
- R3: Channel n below 8 uses bits 4n+3:4n of enable word 0x00 and pending word 0x10. Channel n of 8 or more uses bits 4(n-8)+3:4(n-8) of enable word 0x04 and pending word 0x14.
- R4: A write to 0x10 or 0x14 clears each pending bit whose data bit is 1. Pending bits written with 0 keep their value.
- R5: When an event and a write-one clear hit the same pending bit in the same cycle, the bit ends up set.
- R6: Bit 3 of every nibble reads as 0 in both enable and pending words, and writes to it have no effect.
- R7: `irq_o` is high exactly when some pending bit is set and its enable bit is set. It follows register state with no extra cycle of delay.
- R8: A write to 0x00 or 0x04 replaces bits 0 to 2 of every nibble with the write data, and the new value reads back from the same offset.
- R9: Word 0x30 shows bit n equal to `ch_busy_i[n]`, with 0 above the channel count. Writes to 0x30 are ignored.
- R10: With a channel count of 8, words 0x04 and 0x14 read as 0, and writes to them have no effect.
- R11: Reads from any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_half_i | input | NUM_CH | Half-transfer event pulse per channel |
| ev_desc_i | input | NUM_CH | Descriptor-done event pulse per channel |
| ev_chain_i | input | NUM_CH | Chain-done event pulse per channel |
| ch_busy_i | input | NUM_CH | Busy level per channel |
| reg_wen_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Byte offset for a read or write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Combined interrupt level |

## Verification
Each event pulse and register write takes effect on the clock edge that samples it. The read bus and `irq_o` then show the new state straight away, because both are combinational from the registers. The bench drives stimulus on the falling edge and samples one time unit after the falling edge that follows the capturing rising edge. Each result is therefore due exactly one rising edge after its stimulus. The busy word has no register in its path, so the bench samples it in the same half cycle in which it is driven.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned ADDR_W      = 8;
  localparam int unsigned NIB_W       = 4;
  localparam int unsigned CH_PER_WORD = WORD_W / NIB_W;
  localparam int unsigned EV_KINDS    = 3;

  localparam logic [ADDR_W-1:0] OFS_EN0   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_EN1   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_PEND0 = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_PEND1 = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_BUSY  = 8'h30;

  // Nibble bit positions; bit 3 is reserved.
  localparam int unsigned BIT_HALF  = 0;
  localparam int unsigned BIT_DESC  = 1;
  localparam int unsigned BIT_CHAIN = 2;
endpackage

// File: rtl/dma_irq_chan.sv
module dma_irq_chan
  import dma_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [EV_KINDS-1:0] ev_i,
  input  logic                en_we_i,
  input  logic                clr_we_i,
  input  logic [NIB_W-1:0]    wbits_i,
  output logic [NIB_W-1:0]    pend_o,
  output logic [NIB_W-1:0]    en_o,
  output logic                req_o
);
  logic [EV_KINDS-1:0] pend_q, en_q, clr_mask;

  assign clr_mask = clr_we_i ? wbits_i[EV_KINDS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      // Event has priority over the write-one clear.
      pend_q <= ev_i | (pend_q & ~clr_mask);
      if (en_we_i) en_q <= wbits_i[EV_KINDS-1:0];
    end
  end

  assign pend_o = {1'b0, pend_q};
  assign en_o   = {1'b0, en_q};
  assign req_o  = |(pend_q & en_q);

  assert_event_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i != '0) |=> ((pend_o[EV_KINDS-1:0] & $past(ev_i)) == $past(ev_i)));

  assert_w1c_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && ev_i == '0) |=> ((pend_o[EV_KINDS-1:0] & $past(wbits_i[EV_KINDS-1:0])) == '0));

  assert_pend_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we_i && ev_i == '0) |=> $stable(pend_o));

  assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && ((ev_i & wbits_i[EV_KINDS-1:0]) != '0))
      |=> ((pend_o[EV_KINDS-1:0] & $past(ev_i & wbits_i[EV_KINDS-1:0]))
           == $past(ev_i & wbits_i[EV_KINDS-1:0])));

  assert_enable_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we_i |=> $stable(en_o));
endmodule

// File: rtl/dma_irq_rdmux.sv
module dma_irq_rdmux
  import dma_irq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] en0_i,
  input  logic [WORD_W-1:0] en1_i,
  input  logic [WORD_W-1:0] pend0_i,
  input  logic [WORD_W-1:0] pend1_i,
  input  logic [WORD_W-1:0] busy_i,
  output logic [WORD_W-1:0] rdata_o
);
  always_comb begin
    unique case (addr_i)
      OFS_EN0:   rdata_o = en0_i;
      OFS_EN1:   rdata_o = en1_i;
      OFS_PEND0: rdata_o = pend0_i;
      OFS_PEND1: rdata_o = pend1_i;
      OFS_BUSY:  rdata_o = busy_i;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     ev_half_i,
  input  logic [NUM_CH-1:0]     ev_desc_i,
  input  logic [NUM_CH-1:0]     ev_chain_i,
  input  logic [NUM_CH-1:0]     ch_busy_i,
  input  logic                  reg_wen_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [WORD_W-1:0]     reg_wdata_i,
  output logic [WORD_W-1:0]     reg_rdata_o,
  output logic                  irq_o
);
  localparam int unsigned NUM_WORDS = 2;

  logic [WORD_W-1:0] en_word   [NUM_WORDS];
  logic [WORD_W-1:0] pend_word [NUM_WORDS];
  logic [NUM_WORDS-1:0] en_we, clr_we;
  logic [NUM_CH-1:0] ch_req;
  logic [WORD_W-1:0] busy_word;

  assign en_we[0]  = reg_wen_i && (reg_addr_i == OFS_EN0);
  assign en_we[1]  = reg_wen_i && (reg_addr_i == OFS_EN1);
  assign clr_we[0] = reg_wen_i && (reg_addr_i == OFS_PEND0);
  assign clr_we[1] = reg_wen_i && (reg_addr_i == OFS_PEND1);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar k = 0; k < CH_PER_WORD; k++) begin : g_nib
      localparam int unsigned CH = w * CH_PER_WORD + k;
      if (CH < NUM_CH) begin : g_live
        logic [NIB_W-1:0] pend_n, en_n;
        logic [EV_KINDS-1:0] ev;
        assign ev[BIT_HALF]  = ev_half_i[CH];
        assign ev[BIT_DESC]  = ev_desc_i[CH];
        assign ev[BIT_CHAIN] = ev_chain_i[CH];
        dma_irq_chan u_chan (
          .clk      (clk),
          .rst_n    (rst_n),
          .ev_i     (ev),
          .en_we_i  (en_we[w]),
          .clr_we_i (clr_we[w]),
          .wbits_i  (reg_wdata_i[k*NIB_W +: NIB_W]),
          .pend_o   (pend_n),
          .en_o     (en_n),
          .req_o    (ch_req[CH])
        );
        assign pend_word[w][k*NIB_W +: NIB_W] = pend_n;
        assign en_word[w][k*NIB_W +: NIB_W]   = en_n;
      end else begin : g_absent
        assign pend_word[w][k*NIB_W +: NIB_W] = '0;
        assign en_word[w][k*NIB_W +: NIB_W]   = '0;
      end
    end
  end

  assign busy_word = WORD_W'(ch_busy_i);
  assign irq_o     = |ch_req;

  dma_irq_rdmux u_rdmux (
    .addr_i  (reg_addr_i),
    .en0_i   (en_word[0]),
    .en1_i   (en_word[1]),
    .pend0_i (pend_word[0]),
    .pend1_i (pend_word[1]),
    .busy_i  (busy_word),
    .rdata_o (reg_rdata_o)
  );

  assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_word[0] == '0 && en_word[1] == '0) |-> !irq_o);

  assert_irq_needs_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_word[0] == '0 && pend_word[1] == '0) |-> !irq_o);
endmodule

// File: tb/dma_irq_ctrl_bench.sv
module dma_irq_ctrl_bench;
  localparam int PERIOD = 10;
  localparam int NCH    = 12;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] ev_h = 0, ev_d = 0, ev_c = 0, busy = 0;
  logic wen = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq;

  logic [7:0] s_ev_h = 0, s_ev_d = 0, s_ev_c = 0, s_busy = 0;
  logic s_wen = 0;
  logic [7:0] s_addr = 0;
  logic [31:0] s_wdata = 0, s_rdata;
  logic s_irq;

  int n_run = 0, n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  dma_irq_ctrl #(.NUM_CH(NCH)) u_dma_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_half_i(ev_h), .ev_desc_i(ev_d), .ev_chain_i(ev_c),
    .ch_busy_i(busy), .reg_wen_i(wen), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq));

  dma_irq_ctrl #(.NUM_CH(8)) u_dma_irq_ctrl_n8 (
    .clk(clk), .rst_n(rst_n), .ev_half_i(s_ev_h), .ev_desc_i(s_ev_d), .ev_chain_i(s_ev_c),
    .ch_busy_i(s_busy), .reg_wen_i(s_wen), .reg_addr_i(s_addr), .reg_wdata_i(s_wdata),
    .reg_rdata_o(s_rdata), .irq_o(s_irq));

  // Vector table: {channel[3:0], kind[1:0] (0 half,1 desc,2 chain), addr[7:0], expected[31:0]}
  localparam int NV = 8;
  localparam logic [45:0] VEC [NV] = '{
    {4'd0,  2'd0, 8'h10, 32'h0000_0001},
    {4'd3,  2'd1, 8'h10, 32'h0000_2000},
    {4'd5,  2'd1, 8'h10, 32'h0020_0000},
    {4'd7,  2'd2, 8'h10, 32'h4000_0000},
    {4'd8,  2'd0, 8'h14, 32'h0000_0001},
    {4'd9,  2'd1, 8'h14, 32'h0000_0020},
    {4'd11, 2'd2, 8'h14, 32'h0000_4000},
    {4'd2,  2'd2, 8'h10, 32'h0000_0400}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    addr = a;
    #1;
    chk(rdata, exp, req);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wen = 1; addr = a; wdata = d;
    @(negedge clk);
    wen = 0;
  endtask

  task automatic pulse(input int ch, input int kind);
    if (kind == 0) ev_h[ch] = 1'b1;
    else if (kind == 1) ev_d[ch] = 1'b1;
    else ev_c[ch] = 1'b1;
    @(negedge clk);
    ev_h = 0; ev_d = 0; ev_c = 0;
  endtask

  initial begin
    #(PERIOD * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(8'h00, 0, "R1"); rd(8'h04, 0, "R1"); rd(8'h10, 0, "R1"); rd(8'h14, 0, "R1");
    chk({31'd0, irq}, 0, "R1");

    // Table walk: R2/R3 mapping, R4 clear, R7 no irq without enable
    for (int i = 0; i < NV; i++) begin
      pulse(int'(VEC[i][45:42]), int'(VEC[i][41:40]));
      rd(VEC[i][39:32], VEC[i][31:0], "R2_R3");
      chk({31'd0, irq}, 0, "R7");
      wr(VEC[i][39:32], 32'h0);
      rd(VEC[i][39:32], VEC[i][31:0], "R4 zero write keeps");
      wr(VEC[i][39:32], VEC[i][31:0]);
      rd(VEC[i][39:32], 0, "R4 one write clears");
    end

    // R8 / R6 enable write and readback, reserved bit 3 masked
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h7777_7777, "R8_R6");
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h0000_7777, "R8_R6");
    wr(8'h00, 32'h0000_0400);
    rd(8'h00, 32'h0000_0400, "R8");
    wr(8'h04, 32'h0);

    // R7: enabled chain bit of ch2 only
    pulse(2, 0);
    chk({31'd0, irq}, 0, "R7 half not enabled");
    pulse(2, 2);
    chk({31'd0, irq}, 1, "R7 enabled chain");
    wr(8'h10, 32'h0000_0400);
    chk({31'd0, irq}, 0, "R7 after clear");
    rd(8'h10, 32'h0000_0100, "R4 other bit kept");
    wr(8'h10, 32'h0000_0100);

    // R6: writing bit 3 of pending has no effect
    pulse(1, 1);
    wr(8'h10, 32'h0000_0080);
    rd(8'h10, 32'h0000_0020, "R6");

    // R5 collision: event and clear same cycle on ch1 desc
    ev_d[1] = 1'b1;
    wr(8'h10, 32'h0000_0020);
    ev_d = 0;
    rd(8'h10, 32'h0000_0020, "R5 event wins");
    wr(8'h10, 32'h0000_0020);
    rd(8'h10, 0, "R5 later clear");

    // R9 busy word
    busy = 12'hA5C;
    rd(8'h30, 32'h0000_0A5C, "R9");
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, 32'h0000_0A5C, "R9 write ignored");
    busy = 12'h801;
    rd(8'h30, 32'h0000_0801, "R9");

    // R11 unmapped offsets
    rd(8'h20, 0, "R11"); rd(8'h08, 0, "R11");

    // R10 eight-channel instance
    s_wen = 1; s_addr = 8'h04; s_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    s_addr = 8'h14;
    @(negedge clk);
    s_wen = 0; s_ev_c[7] = 1'b1;
    @(negedge clk);
    s_ev_c = 0; s_addr = 8'h04; #1;
    chk(s_rdata, 0, "R10 word 1 enable");
    s_addr = 8'h14; #1;
    chk(s_rdata, 0, "R10 word 1 pending");
    s_addr = 8'h10; #1;
    chk(s_rdata, 32'h4000_0000, "R10 ch7 in word 0");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule